// File: doc/BRIEF.md
# Chunked SPI Register Frame Master

This block is an SPI master for burst register access to a word-addressed target. The user side issues one request: a write/read flag, a base word address and a length in 32-bit words. Write words come in on a valid/ready stream. Read words go out on a valid/ready stream. The block turns each request into one or more wire frames. Each frame holds the chip select low, shifts a packed 32-bit command word, then moves the payload words.

One frame carries at most 64 payload words. A longer request is cut into successive frames. Each frame carries the smaller of the words still owed and 64, and starts at the previous frame's address plus the words that frame moved. A zero-length request completes at once without touching the wire. A length that does not fit the internal word counter is refused with an error flag.

The wire uses clock-idle-low, sample-on-rise timing with the most significant bit first. SCLK is a parameterised divide of the system clock. Either stream may stall the transfer between words. While stalled, SCLK stays low and chip select stays asserted.

Top module: `spi_frm_master`

## Requirements
- R1: The first 32 bits of every frame are the command word. Bit 31 is the access flag (1 = write, 0 = read). Bits 30..25 are the frame's word count modulo 64 on a read and zero on a write. Bits 24..4 are the frame's target word address. Bits 3..0 are zero.
- R2: SCLK idles low and each high phase lasts CLK_DIV system cycles. MOSI changes only while SCLK is low. MISO is sampled on SCLK rising edges. All words are shifted MSB first.
- R3: On a write, the payload words follow the command word directly. They are taken from the write stream in order, with one handshake per word.
- R4: On a read, the 32 bits received during the command word are dropped. Each later group of 32 received bits becomes one read-stream word, and the first bit received lands in bit 31.
- R5: Each frame carries min(remaining, 64) words. A frame's address is the previous frame's address plus the words that frame carried, modulo 2^21.
- R6: Chip select is low for a whole frame and SCLK toggles only while it is low. Between frames chip select stays high for at least GAP_CYC cycles.
- R7: A request of zero words produces no frame and gives one done pulse with no error.
- R8: A request whose length is 2^CNT_W or more produces no frame and gives one done pulse with the error flag set in the same cycle.
- R9: done_o pulses exactly once per request, when the last frame ends, with chip select high. req_ready_o is high only while no request is in progress.
- R10: A read word held on the output stays valid and unchanged until it is accepted. No received word is lost or overwritten while the stream stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | 21 | Base target word address |
| req_len_i | input | LEN_W | Burst length in words |
| wr_data_i | input | 32 | Write payload word |
| wr_valid_i | input | 1 | Write word offered |
| wr_ready_o | output | 1 | Write word taken this cycle if valid |
| rd_data_o | output | 32 | Read payload word |
| rd_valid_o | output | 1 | Read word held |
| rd_ready_i | input | 1 | Read word accepted |
| done_o | output | 1 | One-cycle pulse at request end |
| err_o | output | 1 | With done_o: length out of range |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to target |
| miso_i | input | 1 | Serial data from target |
| cs_no | output | 1 | Chip select, active low |

## Verification
Some properties are checked on every cycle. SCLK toggles only under an asserted select, and MOSI holds steady while SCLK is high. The idle clock level, the select gap before each frame, the per-frame word count bound and the hold of a stalled read word are also checked every cycle, as is the pairing of the error flag with done. The remaining behaviour can only be shown by the bench's scenarios. That covers the packed command contents, the frame splitting and address advance across the 64-word boundary and the 21-bit address wrap, and the word order on both streams under random stalls. The zero-length and oversized requests that must leave the wire untouched are also covered there.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  localparam int HDR_W      = 32;
  localparam int HDR_ADDR_W = 21;
  localparam int HDR_CNT_W  = 6;
  localparam int HDR_PAD_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_GAP
  } st_e;
endpackage

// File: rtl/spi_frm_shift.sv
module spi_frm_shift #(
  parameter int DIV = 2,
  parameter int W   = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(W);

  logic          busy_q, sclk_q, tick;
  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_q, rx_q;

  assign tick = busy_q && (div_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= data_i;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BW'(W - 1)) begin
            busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = tick && sclk_q && (bit_q == BW'(W - 1));
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_q[W-1];
  assign rx_o   = rx_q;

  // mode 0: data settles while clock is low
  assert_mosi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(mosi_o));
  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
endmodule

// File: rtl/spi_frm_chunk.sv
module spi_frm_chunk #(
  parameter int CNT_W     = 10,
  parameter int MAX_WORDS = 64,
  parameter int FW        = 7
) (
  input  logic                              write_i,
  input  logic [spi_frm_pkg::HDR_ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]                  rem_i,
  output logic [FW-1:0]                     words_o,
  output logic [spi_frm_pkg::HDR_W-1:0]      hdr_o
);
  import spi_frm_pkg::*;

  logic [HDR_CNT_W-1:0] cnt_fld;

  assign words_o = (rem_i > CNT_W'(MAX_WORDS)) ? FW'(MAX_WORDS) : FW'(rem_i);
  // full 64-word frame wraps to zero in the 6-bit field
  assign cnt_fld = write_i ? '0 : words_o[HDR_CNT_W-1:0];
  assign hdr_o   = {write_i, cnt_fld, addr_i, {HDR_PAD_W{1'b0}}};
endmodule

// File: rtl/spi_frm_master.sv
module spi_frm_master #(
  parameter int CLK_DIV   = 2,
  parameter int GAP_CYC   = 4,
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 16,
  parameter int MAX_WORDS = 64
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  output logic                              req_ready_o,
  input  logic                              req_write_i,
  input  logic [spi_frm_pkg::HDR_ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]                  req_len_i,
  input  logic [31:0]                       wr_data_i,
  input  logic                              wr_valid_i,
  output logic                              wr_ready_o,
  output logic [31:0]                       rd_data_o,
  output logic                              rd_valid_o,
  input  logic                              rd_ready_i,
  output logic                              done_o,
  output logic                              err_o,
  output logic                              sclk_o,
  output logic                              mosi_o,
  output logic                              cs_no,
  input  logic                              miso_i
);
  import spi_frm_pkg::*;

  localparam int FW = $clog2(MAX_WORDS + 1);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;
  localparam int HW = $clog2(GAP_CYC + 2) + 1;

  st_e                   st_q;
  logic                  wr_q, cs_q, done_q, err_q, rdv_q;
  logic [HDR_ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]      rem_q;
  logic [FW-1:0]         left_q, fw;
  logic [GW-1:0]         gap_q;
  logic [31:0]           rdd_q, hdr, eng_data, eng_rx;
  logic                  eng_start, eng_busy, eng_done, pay_ok, len_ovf;

  if (LEN_W > CNT_W) begin : g_ovf
    assign len_ovf = |req_len_i[LEN_W-1:CNT_W];
  end else begin : g_no_ovf
    assign len_ovf = 1'b0;
  end

  spi_frm_chunk #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS), .FW(FW)) u_chunk (
    .write_i(wr_q), .addr_i(addr_q), .rem_i(rem_q), .words_o(fw), .hdr_o(hdr)
  );

  assign pay_ok     = (st_q == ST_PAY) && !eng_busy && (left_q != '0);
  assign wr_ready_o = pay_ok && wr_q;
  assign eng_start  = ((st_q == ST_HDR) && !eng_busy) ||
                      (pay_ok && (wr_q ? wr_valid_i : !rdv_q));
  assign eng_data   = (st_q == ST_HDR) ? hdr : (wr_q ? wr_data_i : '0);

  spi_frm_shift #(.DIV(CLK_DIV), .W(32)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(eng_start), .data_i(eng_data),
    .miso_i(miso_i), .busy_o(eng_busy), .done_o(eng_done), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .rx_o(eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      left_q <= '0;
      gap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q   <= req_write_i;
          addr_q <= req_addr_i;
          rem_q  <= req_len_i[CNT_W-1:0];
          if (len_ovf) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (req_len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            st_q <= ST_HDR;
            cs_q <= 1'b0;
          end
        end
        ST_HDR: if (eng_done) begin
          left_q <= fw;
          st_q   <= ST_PAY;
        end
        ST_PAY: if (eng_done) begin
          left_q <= left_q - 1'b1;
          if (left_q == FW'(1)) begin
            addr_q <= addr_q + HDR_ADDR_W'(fw);
            rem_q  <= rem_q - CNT_W'(fw);
            cs_q   <= 1'b1;
            gap_q  <= '0;
            st_q   <= ST_GAP;
            if (rem_q == CNT_W'(fw)) done_q <= 1'b1;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(GAP_CYC - 1)) begin
            if (rem_q == '0) begin
              st_q <= ST_IDLE;
            end else begin
              st_q <= ST_HDR;
              cs_q <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // single-word read holding buffer; next read word starts only once it drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else if ((st_q == ST_PAY) && eng_done && !wr_q) begin
      rdv_q <= 1'b1;
      rdd_q <= eng_rx;
    end else if (rdv_q && rd_ready_i) begin
      rdv_q <= 1'b0;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdd_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cs_no       = cs_q;

  // checker: consecutive cycles with select released
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= HW'(GAP_CYC);
    else if (!cs_q) hi_cnt_q <= '0;
    else if (hi_cnt_q < HW'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> (hi_cnt_q >= HW'(GAP_CYC)));
  assert_sclk_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_q);
  assert_frame_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAY) |-> ((left_q != '0) && (left_q <= FW'(MAX_WORDS))));
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdv_q && !rd_ready_i) |=> (rdv_q && $stable(rdd_q)));
  assert_no_overwrite_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_PAY) && eng_done && !wr_q) |-> !rdv_q);
  assert_err_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q);
  assert_done_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cs_q);
endmodule

// File: tb/spi_frm_master_tb.sv
module spi_frm_master_tb;
  localparam int CLK_DIV = 2;
  localparam int GAP_CYC = 3;
  localparam int CNT_W   = 10;
  localparam int LEN_W   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [20:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [31:0] wr_data, rd_data;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic        done, err, sclk, mosi, cs_n, miso;

  spi_frm_master #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_len_i(req_len),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .done_o(done), .err_o(err), .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n), .miso_i(miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(logic [20:0] x);
    return ({11'd0, x} * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] wdat(int id, int k);
    return {8'(id), 24'(k)} ^ 32'h5A0F_3C96;
  endfunction

  function automatic logic [31:0] exp_hdr(bit w, logic [20:0] a, int n);
    logic [5:0] c;
    c = w ? 6'd0 : 6'(n);
    return {w, c, a, 4'b0000};
  endfunction

  // target model
  int          rc = 0, mc = 0;
  logic [31:0] sh = '0, hdr_cur = '0;
  logic [31:0] hdr_q[$], mosi_q[$], rd_got[$];
  int          wcnt_q[$];
  bit          framed = 1'b0;
  int          hi_cnt = 1000;

  function automatic logic miso_f(int m, logic [31:0] h);
    int          i;
    logic [20:0] ad;
    logic [31:0] v;
    if (m < 32) return m[1];
    i  = (m - 32) / 32;
    ad = h[24:4] + 21'(i);
    v  = pat(ad);
    return v[31 - (m % 32)];
  endfunction

  assign miso = cs_n ? 1'b0 : miso_f(mc, hdr_cur);

  always @(negedge cs_n) begin
    chk(hi_cnt >= GAP_CYC, "R6", "select high gap", hi_cnt, GAP_CYC);
    rc = 0;
    mc = 0;
    framed = 1'b1;
  end

  always @(posedge cs_n) if (framed) begin
    chk(rc % 32 == 0, "R6", "bits per frame multiple of 32", rc, 0);
    hdr_q.push_back(hdr_cur);
    wcnt_q.push_back(rc / 32 - 1);
  end

  always @(posedge sclk) begin
    sh = {sh[30:0], mosi};
    rc++;
    if (rc % 32 == 0) begin
      if (rc == 32) hdr_cur = sh;
      else mosi_q.push_back(sh);
    end
  end

  always @(negedge sclk) mc++;

  // streams and wire timing, sampled away from the active edge
  bit   stall = 1'b0;
  int   req_id = 0, wr_idx = 0, wr_total = 0;
  bit   wr_fire = 1'b0, rd_fire = 1'b0;
  logic [31:0] rd_save = '0;
  int   hw_cnt = 0, done_cnt = 0, err_cnt = 0;

  always @(negedge clk) if (rst_n) begin
    if (cs_n) begin
      if (hi_cnt < 100000) hi_cnt++;
    end else hi_cnt = 0;
    if (sclk) hw_cnt++;
    else if (hw_cnt != 0) begin
      chk(hw_cnt == CLK_DIV, "R2", "sclk high width", hw_cnt, CLK_DIV);
      hw_cnt = 0;
    end
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (wr_fire) wr_idx++;
    if (rd_fire) rd_got.push_back(rd_save);
    wr_valid = (wr_idx < wr_total) && (!stall || ($urandom % 4 != 0));
    wr_data  = wdat(req_id, wr_idx);
    wr_fire  = wr_valid && wr_ready;
    rd_ready = !stall || ($urandom % 3 == 0);
    rd_fire  = rd_valid && rd_ready;
    rd_save  = rd_data;
  end

  task automatic run_req(bit w, logic [20:0] a, int n, bit st);
    int nf, mism, words;
    logic [20:0] fa;
    bit ovf;
    ovf = (n >= (1 << CNT_W));
    nf  = ovf ? 0 : (n + 63) / 64;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_id++;
    stall = st;
    hdr_q.delete(); wcnt_q.delete(); mosi_q.delete(); rd_got.delete();
    done_cnt = 0; err_cnt = 0;
    wr_idx = 0; wr_total = (w && !ovf) ? n : 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_len = LEN_W'(n);
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    while (!req_ready || rd_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(err_cnt == (ovf ? 1 : 0), "R8", "error flag", err_cnt, ovf ? 1 : 0);
    chk(hdr_q.size() == nf, (n == 0) ? "R7" : "R5", "frame count", hdr_q.size(), nf);
    for (int j = 0; j < nf && j < hdr_q.size(); j++) begin
      words = (n - 64 * j > 64) ? 64 : n - 64 * j;
      fa    = a + 21'(64 * j);
      chk(hdr_q[j] == exp_hdr(w, fa, words), "R1", "command word", hdr_q[j], exp_hdr(w, fa, words));
      chk(wcnt_q[j] == words, "R5", "words in frame", wcnt_q[j], words);
    end
    if (w) begin
      chk(mosi_q.size() == (ovf ? 0 : n), "R3", "write words on wire", mosi_q.size(), ovf ? 0 : n);
      mism = 0;
      for (int k = 0; k < mosi_q.size(); k++) if (mosi_q[k] != wdat(req_id, k)) mism++;
      chk(mism == 0, "R3", "write payload mismatches", mism, 0);
    end else begin
      chk(rd_got.size() == (ovf ? 0 : n), "R4", "read words delivered", rd_got.size(), ovf ? 0 : n);
      mism = 0;
      for (int k = 0; k < rd_got.size(); k++) if (rd_got[k] != pat(a + 21'(k))) mism++;
      chk(mism == 0, "R10", "read payload mismatches under stall", mism, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd9157));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R6", "reset select", cs_n, 1);
    chk(sclk == 1'b0, "R2", "reset sclk", sclk, 0);
    chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R10", "reset read valid", rd_valid, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);

    run_req(1'b1, 21'h00_0100, 0, 1'b0);      // R7 zero-length write
    run_req(1'b0, 21'h00_0200, 0, 1'b0);      // R7 zero-length read
    run_req(1'b1, 21'h00_1000, 2000, 1'b0);   // R8 oversized
    run_req(1'b0, 21'h00_0040, 1024, 1'b0);   // R8 first value past the counter
    run_req(1'b1, 21'h00_0010, 1, 1'b0);
    run_req(1'b0, 21'h00_0020, 1, 1'b0);
    run_req(1'b1, 21'h01_2340, 64, 1'b0);     // R5 exactly one full frame
    run_req(1'b0, 21'h00_0300, 65, 1'b1);     // R5 spill of one word
    run_req(1'b1, 21'h00_0500, 130, 1'b1);
    run_req(1'b0, 21'h1F_FFF0, 70, 1'b1);     // R5 address wrap
    for (int r = 0; r < 5; r++)
      run_req(1'($urandom % 2), 21'($urandom), 1 + int'($urandom % 80), 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule